// File: doc/BRIEF.md
# Engine Speed Converter

This block turns the interval between cam-driven position pulses into engine-speed words. The interval arrives as a 16-bit count of timer ticks, one tick being a 12.5829 MHz clock divided by 64 (about 5.086 µs). Four such pulses occur per crank revolution, so the count covers a quarter turn. A single-cycle strobe starts a conversion. The block then runs two restoring fractional dividers side by side, each computing a constant times 2^16 divided by the count, one quotient bit per clock.

The first divider uses the constant 180 and gives a speed word scaled to four times RPM. A result at or below 45 RPM is reported as zero, meaning the engine is stopped. The second divider uses the constant 461 and feeds two rounded byte outputs: a coarse byte at RPM/25 and a fine byte at RPM/12.5. Both bytes saturate to 0xFF. When the outputs are ready, `done_o` pulses and the outputs hold their values until the next result. A count of about 2949 ticks corresponds to 1000 RPM, giving 4000, 0x28 and 0x50.

Top module: `esp_speed_calc`

## Requirements
- R1: For a period P greater than 180, `speed_x4_o` equals floor(180·65536/P), unless R3 applies.
- R2: When P is at most the divider constant, that divider's quotient saturates to 0xFFFF. This includes P = 0. So P ≤ 180 gives `speed_x4_o` = 0xFFFF, and P ≤ 461 gives 0xFF on both byte outputs.
- R3: When the quotient from R1 is 180 or less, `speed_x4_o` is 0.
- R4: Let Q = floor(461·65536/P), saturated per R2. `speed_coarse_o` is bits 15:8 of Q + 0x80. If that sum carries past 16 bits, the output is 0xFF.
- R5: `speed_fine_o` applies the R4 rounding to 2·Q. It is 0xFF if either the doubling or the rounding exceeds 16 bits.
- R6: `done_o` is high for exactly one cycle. It rises on the 17th rising edge after the edge that accepted the strobe.
- R7: `busy_o` is high from the cycle after acceptance until `done_o` rises. A strobe seen while busy is ignored and neither changes the pending result nor queues a second conversion.
- R8: Reset clears all outputs to zero. Between `done_o` pulses, the three speed outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | 16 | Tick count between position pulses |
| period_valid_i | input | 1 | Start strobe, sampled when idle |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse, results updated |
| speed_x4_o | output | 16 | Four times RPM, zero when stopped |
| speed_coarse_o | output | 8 | Rounded RPM/25, saturating |
| speed_fine_o | output | 8 | Rounded RPM/12.5, saturating |

## Verification
Three outcomes come from narrow bands of the period: the stopped threshold, the point where doubling the byte quotient overflows, and the point where rounding carries into the upper byte. None of these is reached by sweeping round numbers.

The stimulus table therefore includes hand-computed periods on each side of the 181/180 quotient boundary (65173 and 65174), a period whose doubled quotient overflows while the single one does not (600), and periods at and just above each divider constant.

A second strobe is injected partway through a conversion. The bench then checks that the reported result still belongs to the first period and that no extra `done_o` follows.

// File: rtl/esp_pkg.sv
package esp_pkg;

    localparam int unsigned WORD_W     = 16;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned ROUND_BIAS = 1 << (WORD_W - BYTE_W - 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WRAP = 2'd2
    } esp_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] x4;
        logic [BYTE_W-1:0] coarse;
        logic [BYTE_W-1:0] fine;
    } speed_set_t;

    // Round a value of up to WORD_W+1 bits to its upper byte, saturating on carry
    function automatic logic [BYTE_W-1:0] round_hi(input logic [WORD_W:0] v);
        logic [WORD_W+1:0] s;
        s = {1'b0, v} + (WORD_W+2)'(ROUND_BIAS);
        if (s[WORD_W+1:WORD_W] != 2'b00)
            return '1;
        else
            return s[WORD_W-1 -: BYTE_W];
    endfunction

endpackage

// File: rtl/esp_frac_div.sv
module esp_frac_div #(
    parameter int unsigned W = 16,
    parameter int unsigned K = 180
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [W-1:0] period_i,
    output logic [W-1:0] quot_o
);
    localparam logic [W-1:0] K_W = W'(K);

    logic [W-1:0] rem_q, div_q, quot_q;
    logic         sat_q;
    logic [W:0]   trial;
    logic         fits;
    logic [W-1:0] rem_sub;

    always_comb begin
        trial   = {rem_q, 1'b0};
        fits    = (trial >= {1'b0, div_q});
        rem_sub = W'(trial - {1'b0, div_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            div_q  <= '0;
            quot_q <= '0;
            sat_q  <= 1'b0;
        end else if (load_i) begin
            rem_q  <= K_W;
            div_q  <= period_i;
            quot_q <= '0;
            sat_q  <= (K_W >= period_i);
        end else if (step_i) begin
            if (fits) begin
                rem_q  <= rem_sub;
                quot_q <= {quot_q[W-2:0], 1'b1};
            end else begin
                rem_q  <= trial[W-1:0];
                quot_q <= {quot_q[W-2:0], 1'b0};
            end
        end
    end

    assign quot_o = sat_q ? '1 : quot_q;

endmodule

// File: rtl/esp_seq.sv
module esp_seq
    import esp_pkg::*;
#(
    parameter int unsigned STEPS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic finish_o,
    output logic busy_o
);
    localparam int unsigned CW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    esp_state_e state_q;
    logic [CW-1:0] cnt_q;

    assign load_o   = (state_q == ST_IDLE) && start_i;
    assign step_o   = (state_q == ST_RUN);
    assign finish_o = (state_q == ST_WRAP);
    assign busy_o   = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q <= ST_RUN;
                    cnt_q   <= '0;
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) state_q <= ST_WRAP;
                end
                ST_WRAP: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/esp_scale.sv
module esp_scale
    import esp_pkg::*;
#(
    parameter int unsigned STOP_LIMIT = 180
) (
    input  logic [WORD_W-1:0] quot_x4_i,
    input  logic [WORD_W-1:0] quot_byte_i,
    output speed_set_t        res_o
);
    localparam logic [WORD_W-1:0] STOP_W = WORD_W'(STOP_LIMIT);

    always_comb begin
        res_o.x4     = (quot_x4_i <= STOP_W) ? '0 : quot_x4_i;
        res_o.coarse = round_hi({1'b0, quot_byte_i});
        res_o.fine   = round_hi({quot_byte_i, 1'b0});
    end

endmodule

// File: rtl/esp_speed_calc.sv
module esp_speed_calc
    import esp_pkg::*;
#(
    parameter int unsigned X4_K       = 180,
    parameter int unsigned BYTE_K     = 461,
    parameter int unsigned STOP_LIMIT = 180
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] period_i,
    input  logic              period_valid_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] speed_x4_o,
    output logic [BYTE_W-1:0] speed_coarse_o,
    output logic [BYTE_W-1:0] speed_fine_o
);
    localparam int unsigned NDIV = 2;
    localparam int unsigned DIV_K [NDIV] = '{X4_K, BYTE_K};

    logic load, step, finish;
    logic [WORD_W-1:0] quot [NDIV];
    speed_set_t res_next, res_q;
    logic done_q;

    esp_seq #(.STEPS(WORD_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (period_valid_i),
        .load_o   (load),
        .step_o   (step),
        .finish_o (finish),
        .busy_o   (busy_o)
    );

    for (genvar g = 0; g < NDIV; g++) begin : g_div
        esp_frac_div #(.W(WORD_W), .K(DIV_K[g])) u_div (
            .clk      (clk),
            .rst      (rst),
            .load_i   (load),
            .step_i   (step),
            .period_i (period_i),
            .quot_o   (quot[g])
        );
    end

    esp_scale #(.STOP_LIMIT(STOP_LIMIT)) u_scale (
        .quot_x4_i   (quot[0]),
        .quot_byte_i (quot[1]),
        .res_o       (res_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) res_q <= res_next;
        end
    end

    assign done_o         = done_q;
    assign speed_x4_o     = res_q.x4;
    assign speed_coarse_o = res_q.coarse;
    assign speed_fine_o   = res_q.fine;

endmodule

// File: rtl/esp_speed_calc_chk.sv
module esp_speed_calc_chk #(
    parameter int unsigned STOP_LIMIT = 180
) (
    input logic        clk,
    input logic        rst,
    input logic        period_valid_i,
    input logic        busy_o,
    input logic        done_o,
    input logic [15:0] speed_x4_o,
    input logic [7:0]  speed_coarse_o,
    input logic [7:0]  speed_fine_o
);
    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_idle_at_done_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    assert_accept_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && period_valid_i) |=> busy_o);

    assert_stop_band_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (speed_x4_o == 16'd0 || speed_x4_o > 16'(STOP_LIMIT)));

    assert_fine_sat_R5: assert property (@(posedge clk) disable iff (rst)
        (done_o && speed_coarse_o == 8'hFF) |-> (speed_fine_o == 8'hFF));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(speed_x4_o) && $stable(speed_coarse_o) && $stable(speed_fine_o)));

endmodule

bind esp_speed_calc esp_speed_calc_chk #(.STOP_LIMIT(STOP_LIMIT)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .period_valid_i (period_valid_i),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .speed_x4_o     (speed_x4_o),
    .speed_coarse_o (speed_coarse_o),
    .speed_fine_o   (speed_fine_o)
);

// File: tb/esp_speed_calc_tb.sv
module esp_speed_calc_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] period = '0;
    logic        valid = 1'b0;
    logic        busy, done;
    logic [15:0] x4;
    logic [7:0]  coarse, fine;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    esp_speed_calc dut_i (
        .clk            (clk),
        .rst            (rst),
        .period_i       (period),
        .period_valid_i (valid),
        .busy_o         (busy),
        .done_o         (done),
        .speed_x4_o     (x4),
        .speed_coarse_o (coarse),
        .speed_fine_o   (fine)
    );

    // {period, x4, coarse, fine}, hand-computed from the requirements
    localparam int NV = 11;
    localparam logic [47:0] VEC [NV] = '{
        {16'd2949,  16'h0FA0, 8'h28, 8'h50},
        {16'd1000,  16'h2E14, 8'h76, 8'hEC},
        {16'd600,   16'h4CCC, 8'hC5, 8'hFF},
        {16'd462,   16'h63BD, 8'hFF, 8'hFF},
        {16'd181,   16'hFE95, 8'hFF, 8'hFF},
        {16'd180,   16'hFFFF, 8'hFF, 8'hFF},
        {16'd0,     16'hFFFF, 8'hFF, 8'hFF},
        {16'd60000, 16'h00C4, 8'h02, 8'h04},
        {16'd65173, 16'h00B5, 8'h02, 8'h04},
        {16'd65174, 16'h0000, 8'h02, 8'h04},
        {16'd65535, 16'h0000, 8'h02, 8'h04}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Pulse the strobe for one cycle, then wait for done; returns negedges counted
    task automatic run_one(input logic [15:0] p, input bit inject, output int lat);
        @(negedge clk);
        period = p;
        valid  = 1'b1;
        @(negedge clk);
        valid  = 1'b0;
        lat = 1;
        while (done !== 1'b1 && lat < 100) begin
            if (inject && lat == 4) begin
                period = 16'd600;
                valid  = 1'b1;
            end else begin
                valid  = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        valid = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 reset x4", {16'd0, x4}, 32'd0);
        check("R8 reset coarse", {24'd0, coarse}, 32'd0);
        check("R8 reset fine", {24'd0, fine}, 32'd0);
        check("R8 reset done/busy", {30'd0, done, busy}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run_one(VEC[i][47:32], 1'b0, lat);
            check("R6 latency", lat, 32'd18);
            check("R1 R2 R3 x4", {16'd0, x4}, {16'd0, VEC[i][31:16]});
            check("R4 coarse", {24'd0, coarse}, {24'd0, VEC[i][15:8]});
            check("R5 fine", {24'd0, fine}, {24'd0, VEC[i][7:0]});
        end

        // R2: zero period saturates every output
        run_one(16'd0, 1'b0, lat);
        check("R2 zero period", {x4, coarse, fine}, 32'hFFFFFFFF);

        // R3: quotient of exactly 180 reads as stopped
        run_one(16'd65174, 1'b0, lat);
        check("R3 stop threshold", {16'd0, x4}, 32'd0);

        // R6: done lasts one cycle
        @(negedge clk);
        check("R6 done width", {31'd0, done}, 32'd0);

        // R8: outputs hold between results
        repeat (5) @(negedge clk);
        check("R8 hold x4", {16'd0, x4}, 32'd0);
        check("R8 hold coarse", {24'd0, coarse}, 32'h02);

        // R7: strobe during busy ignored
        run_one(16'd2949, 1'b1, lat);
        check("R7 ignored strobe latency", lat, 32'd18);
        check("R7 ignored strobe x4", {16'd0, x4}, 32'h0FA0);
        check("R7 ignored strobe fine", {24'd0, fine}, 32'h50);
        check("R7 busy after done", {31'd0, busy}, 32'd0);
        begin
            int extra = 0;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (done === 1'b1) extra++;
            end
            check("R7 no queued conversion", extra, 32'd0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule